// File: doc/BRIEF.md
# Multi-Cycle RISC Instruction Sequencer

This block is a small non-pipelined integer core for a load-store instruction set. Each instruction moves through a fixed sequence of steps: fetch, decode with register read, execute or address compute, memory access, and write-back. An instruction leaves the sequence as soon as its work is complete. A conditional branch resolves during decode and retires after 2 cycles. A store retires after its memory write in 4 cycles. Every other defined instruction takes 5 cycles.

The core reads instructions from a combinational instruction-memory port. It uses a single-cycle data-memory port, where read data returns in the same cycle as the address and a write commits at the clock edge. It holds 32 general registers, with register 0 fixed at zero. Two counters are exposed so that the cycles-per-instruction of a known instruction mix can be measured directly: one counts cycles since reset and the other counts retired instructions.

Top module: `seq_core`

## Requirements
- R1: While reset is asserted and after it is released, the fetch address is 0x00000000, both counters read zero and the data write enable is low until the first instruction reaches its memory step.
- R2: Fields use MSB-first numbering. The opcode is IR[0..5] (word bits 31:26), the first source is IR[6..10] (25:21), the second source is IR[11..15] (20:16), the reg-reg destination is IR[16..20] (15:11) and the 16-bit immediate is IR[16..31] (15:0). Opcodes 0x00..0x07 are reg-reg operations with function code = opcode[2:0]: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 signed set-less-than, 6 and 7 pass the second operand. The result is written to IR[16..20].
- R3: Opcodes 0x08..0x0F are reg-immediate operations with the same function code on opcode[2:0]. The second operand is the immediate sign-extended to 32 bits, and the result is written to the register at IR[11..15].
- R4: Opcode 0x20 loads the word at first-source + sign-extended immediate into the register at IR[11..15] and takes 5 cycles.
- R5: Opcode 0x28 writes the second-source register to address first-source + sign-extended immediate. The data write enable is high for exactly one cycle, and the instruction retires in that cycle, 4 cycles after its fetch began.
- R6: Opcode 0x30 branches when the two source registers are equal, and opcode 0x31 branches when they differ. The target is (fetch address + 4) + sign-extended immediate. A branch retires after 2 cycles whether or not it is taken.
- R7: Register 0 reads as zero, and writes to it have no effect.
- R8: Reg-reg and reg-immediate operations take 5 cycles. The cycle counter increments once per clock after reset, and the retired counter increments by one when each instruction completes.
- R9: Any other opcode retires after 2 cycles with no register or memory change, and execution continues at the next sequential word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Instruction fetch byte address |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data byte address |
| dmem_we | output | 1 | Data write enable |
| dmem_wdata | output | 32 | Data to write |
| dmem_rdata | input | 32 | Data word at dmem_addr |
| retired_cnt | output | CNT_W | Instructions completed since reset |
| cycle_cnt | output | CNT_W | Clock cycles since reset |

## Verification
The bench targets sign extension at the 16-bit boundary: 0x7FFF + 1, a negative load offset, and a backward branch. A core that zero-extends the immediate stores wrong sums and loops the wrong number of times. Both reg-reg and reg-immediate results are checked through stores, so a core that swaps the two destination fields writes the wrong register. Writes to register 0 and undefined opcodes are checked for absence of effect, and a core that lets either through stores a changed value. The exact cycle and retirement counts for branch-taken, branch-not-taken, load/store and loop mixes expose any class that spends one cycle too many or too few.

// File: rtl/seq_core.sv
module seq_core #(
  parameter logic [31:0] RST_PC = 32'h0,
  parameter int          CNT_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [31:0]      imem_addr,
  input  logic [31:0]      imem_rdata,
  output logic [31:0]      dmem_addr,
  output logic             dmem_we,
  output logic [31:0]      dmem_wdata,
  input  logic [31:0]      dmem_rdata,
  output logic [CNT_W-1:0] retired_cnt,
  output logic [CNT_W-1:0] cycle_cnt
);

  typedef enum logic [2:0] {S_IF, S_ID, S_EX, S_MEM, S_WB} step_t;

  step_t       step;
  logic [31:0] pc, npc, ir, a, b, imm, alu_out, lmd;
  logic [31:0] rf [32];

  wire [5:0]  opc    = ir[31:26];
  wire [4:0]  src1   = ir[25:21];
  wire [4:0]  src2   = ir[20:16];
  wire [4:0]  dst_rr = ir[15:11];
  wire [31:0] sext   = {{16{ir[15]}}, ir[15:0]};

  wire is_rr  = opc[5:3] == 3'b000;
  wire is_ri  = opc[5:3] == 3'b001;
  wire is_ld  = opc == 6'h20;
  wire is_st  = opc == 6'h28;
  wire is_beq = opc == 6'h30;
  wire is_bne = opc == 6'h31;
  wire is_long = is_rr | is_ri | is_ld | is_st;

  wire [31:0] rv1 = (src1 == 5'd0) ? 32'h0 : rf[src1];
  wire [31:0] rv2 = (src2 == 5'd0) ? 32'h0 : rf[src2];
  wire        cond = (is_beq & (rv1 == rv2)) | (is_bne & (rv1 != rv2));
  wire [31:0] target = npc + sext;

  wire [4:0]  wb_idx = is_rr ? dst_rr : src2;

  function automatic logic [31:0] alu_f(input logic [2:0] f, input logic [31:0] x, input logic [31:0] y);
    case (f)
      3'd0:    alu_f = x + y;
      3'd1:    alu_f = x - y;
      3'd2:    alu_f = x & y;
      3'd3:    alu_f = x | y;
      3'd4:    alu_f = x ^ y;
      3'd5:    alu_f = {31'h0, $signed(x) < $signed(y)};
      default: alu_f = y;
    endcase
  endfunction

  assign imem_addr  = pc;
  assign dmem_addr  = alu_out;
  assign dmem_wdata = b;
  assign dmem_we    = (step == S_MEM) && is_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step        <= S_IF;
      pc          <= RST_PC;
      npc         <= RST_PC;
      ir          <= 32'h0;
      a           <= 32'h0;
      b           <= 32'h0;
      imm         <= 32'h0;
      alu_out     <= 32'h0;
      lmd         <= 32'h0;
      retired_cnt <= '0;
      cycle_cnt   <= '0;
    end else begin
      cycle_cnt <= cycle_cnt + 1'b1;
      case (step)
        S_IF: begin
          ir   <= imem_rdata;
          npc  <= pc + 32'd4;
          step <= S_ID;
        end
        S_ID: begin
          a       <= rv1;
          b       <= rv2;
          imm     <= sext;
          alu_out <= target;
          pc      <= cond ? target : npc;
          if (is_long) begin
            step <= S_EX;
          end else begin
            step        <= S_IF;
            retired_cnt <= retired_cnt + 1'b1;
          end
        end
        S_EX: begin
          if (is_ld || is_st) alu_out <= a + imm;
          else                alu_out <= alu_f(opc[2:0], a, is_rr ? b : imm);
          step <= S_MEM;
        end
        S_MEM: begin
          if (is_ld) lmd <= dmem_rdata;
          if (is_st) begin
            step        <= S_IF;
            retired_cnt <= retired_cnt + 1'b1;
          end else begin
            step <= S_WB;
          end
        end
        S_WB: begin
          step        <= S_IF;
          retired_cnt <= retired_cnt + 1'b1;
        end
        default: step <= S_IF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (step == S_WB && wb_idx != 5'd0)
      rf[wb_idx] <= is_ld ? lmd : alu_out;
  end

endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dmem_we,
  input logic [CNT_W-1:0] retired_cnt,
  input logic [CNT_W-1:0] cycle_cnt
);

  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> !dmem_we);

  p_store_retires_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> retired_cnt == $past(retired_cnt) + 1'b1);

  p_cycle_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cycle_cnt == $past(cycle_cnt) + 1'b1);

  p_retire_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (retired_cnt == $past(retired_cnt)) || (retired_cnt == $past(retired_cnt) + 1'b1));

  p_retire_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    retired_cnt <= cycle_cnt);

endmodule

bind seq_core seq_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .dmem_we(dmem_we),
  .retired_cnt(retired_cnt),
  .cycle_cnt(cycle_cnt)
);

// File: tb/tb_seq_core.sv
`timescale 1ns/1ps
module tb_seq_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [31:0] retired_cnt, cycle_cnt;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int          wecnt;
  int          nchk = 0;
  int          nfail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  seq_core dut (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .retired_cnt(retired_cnt), .cycle_cnt(cycle_cnt)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (!rst_n) wecnt <= 0;
    else if (dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
      wecnt <= wecnt + 1;
    end
  end

  function automatic logic [31:0] ei(input logic [5:0] op, input logic [4:0] s, input logic [4:0] t, input logic [15:0] im);
    return {op, s, t, im};
  endfunction

  function automatic logic [31:0] er(input logic [5:0] op, input logic [4:0] s, input logic [4:0] t, input logic [4:0] d);
    return {op, s, t, d, 11'h0};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
  endtask

  task automatic run(input int n);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  localparam int NV = 14;
  // {opcode, a, b_or_imm, expected}
  localparam logic [69:0] VEC [NV] = '{
    {6'h00, 16'h0005, 16'h0007, 32'h0000000C},
    {6'h01, 16'h0003, 16'h000A, 32'hFFFFFFF9},
    {6'h02, 16'h00F0, 16'h0FF0, 32'h000000F0},
    {6'h03, 16'h0F00, 16'h00F0, 32'h00000FF0},
    {6'h04, 16'h00FF, 16'h0F0F, 32'h00000FF0},
    {6'h05, 16'hFFFF, 16'h0001, 32'h00000001},
    {6'h05, 16'h0001, 16'hFFFF, 32'h00000000},
    {6'h06, 16'h0001, 16'h8000, 32'hFFFF8000},
    {6'h08, 16'h7FFF, 16'h0001, 32'h00008000},
    {6'h09, 16'h0000, 16'h0001, 32'hFFFFFFFF},
    {6'h0A, 16'hFFFF, 16'h8000, 32'hFFFF8000},
    {6'h0B, 16'h0001, 16'h8000, 32'hFFFF8001},
    {6'h0C, 16'h1234, 16'hFFFF, 32'hFFFFEDCB},
    {6'h0D, 16'h8000, 16'h7FFF, 32'h00000001}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    hold_reset();
    check("R1 fetch addr in reset", imem_addr, 32'h0);
    check("R1 retired in reset", retired_cnt, 32'h0);
    check("R1 cycles in reset", cycle_cnt, 32'h0);
    check("R1 no write in reset", {31'h0, dmem_we}, 32'h0);
    run(1);
    check("R1 fetch addr after release", imem_addr, 32'h0);
    check("R1 cycles after one edge", cycle_cnt, 32'h1);

    // R2 R3 ALU vectors, result stored to 0x40
    for (int v = 0; v < NV; v++) begin
      logic [5:0]  op;
      logic [15:0] va, vb;
      logic [31:0] ve;
      {op, va, vb, ve} = VEC[v];
      hold_reset();
      imem[0] = ei(6'h0E, 5'd0, 5'd1, va);
      if (op[5:3] == 3'b000) begin
        imem[1] = ei(6'h0E, 5'd0, 5'd2, vb);
        imem[2] = er(op, 5'd1, 5'd2, 5'd3);
        imem[3] = ei(6'h28, 5'd0, 5'd3, 16'h0040);
      end else begin
        imem[1] = ei(op, 5'd1, 5'd3, vb);
        imem[2] = ei(6'h28, 5'd0, 5'd3, 16'h0040);
      end
      run(19);
      check(op[3] ? "R3 reg-imm result" : "R2 reg-reg result", dmem[16], ve);
    end

    // R4 R5 loads incl. negative offset, store timing
    hold_reset();
    dmem[20] = 32'hDEADBEEF;
    dmem[22] = 32'h13579BDF;
    imem[0] = ei(6'h20, 5'd0, 5'd5, 16'h0050);
    imem[1] = ei(6'h28, 5'd0, 5'd5, 16'h0044);
    imem[2] = ei(6'h0E, 5'd0, 5'd6, 16'h0060);
    imem[3] = ei(6'h20, 5'd6, 5'd7, 16'hFFF8);
    imem[4] = ei(6'h28, 5'd0, 5'd7, 16'h0048);
    run(5);
    check("R4 load retires at cycle 5", retired_cnt, 32'd1);
    run(3);
    check("R5 store not done at cycle 8", dmem[17], 32'h0);
    run(1);
    check("R5 store retires at cycle 9", retired_cnt, 32'd2);
    check("R4 loaded word stored", dmem[17], 32'hDEADBEEF);
    run(14);
    check("R4 negative offset load", dmem[18], 32'h13579BDF);
    check("R8 retired after mix", retired_cnt, 32'd5);
    check("R8 cycles after mix", cycle_cnt, 32'd23);
    check("R5 one write per store", wecnt, 32'd2);

    // R7 register zero
    hold_reset();
    dmem[16] = 32'hFFFFFFFF;
    imem[0] = ei(6'h0E, 5'd0, 5'd0, 16'h0077);
    imem[1] = ei(6'h0E, 5'd0, 5'd1, 16'h0005);
    imem[2] = er(6'h00, 5'd0, 5'd1, 5'd2);
    imem[3] = ei(6'h28, 5'd0, 5'd0, 16'h0040);
    imem[4] = ei(6'h28, 5'd0, 5'd2, 16'h0044);
    run(23);
    check("R7 r0 stored as zero", dmem[16], 32'h0);
    check("R7 r0 operand reads zero", dmem[17], 32'h5);

    // R6 taken branch
    hold_reset();
    imem[0] = ei(6'h0E, 5'd0, 5'd4, 16'h00AA);
    imem[1] = ei(6'h0E, 5'd0, 5'd1, 16'h0003);
    imem[2] = ei(6'h0E, 5'd0, 5'd2, 16'h0003);
    imem[3] = ei(6'h30, 5'd1, 5'd2, 16'h0004);
    imem[4] = ei(6'h0E, 5'd0, 5'd4, 16'h0055);
    imem[5] = ei(6'h28, 5'd0, 5'd4, 16'h0040);
    run(17);
    check("R6 branch retires at cycle 17", retired_cnt, 32'd4);
    run(4);
    check("R6 taken branch skips", dmem[16], 32'h000000AA);
    check("R6 taken retired", retired_cnt, 32'd5);

    // R6 not-taken branch
    hold_reset();
    imem[0] = ei(6'h0E, 5'd0, 5'd4, 16'h00AA);
    imem[1] = ei(6'h0E, 5'd0, 5'd1, 16'h0003);
    imem[2] = ei(6'h0E, 5'd0, 5'd2, 16'h0003);
    imem[3] = ei(6'h31, 5'd1, 5'd2, 16'h0004);
    imem[4] = ei(6'h0E, 5'd0, 5'd4, 16'h0055);
    imem[5] = ei(6'h28, 5'd0, 5'd4, 16'h0040);
    run(26);
    check("R6 not-taken falls through", dmem[16], 32'h00000055);
    check("R6 not-taken retired", retired_cnt, 32'd6);

    // R6 R8 backward loop, CPI mix
    hold_reset();
    imem[0] = ei(6'h0E, 5'd0, 5'd1, 16'h0003);
    imem[1] = ei(6'h0E, 5'd0, 5'd2, 16'h0000);
    imem[2] = ei(6'h08, 5'd2, 5'd2, 16'h0001);
    imem[3] = ei(6'h31, 5'd1, 5'd2, 16'hFFF8);
    imem[4] = ei(6'h28, 5'd0, 5'd2, 16'h0040);
    run(34);
    check("R8 loop retired at cycle 34", retired_cnt, 32'd8);
    run(1);
    check("R6 backward loop count", dmem[16], 32'h3);
    check("R8 loop retired at cycle 35", retired_cnt, 32'd9);
    check("R8 loop cycles", cycle_cnt, 32'd35);

    // R9 undefined opcode
    hold_reset();
    imem[0] = ei(6'h0E, 5'd0, 5'd1, 16'h0042);
    imem[1] = ei(6'h3F, 5'd0, 5'd1, 16'h9999);
    imem[2] = ei(6'h28, 5'd0, 5'd1, 16'h0040);
    run(7);
    check("R9 undefined retires in 2", retired_cnt, 32'd2);
    run(4);
    check("R9 no register change", dmem[16], 32'h42);
    check("R9 retired total", retired_cnt, 32'd3);
    check("R9 no extra write", wecnt, 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule